// File: doc/BRIEF.md
# Power-Pulsing Phase Sequencer

This block sequences the duty-cycled operating phases of a front-end readout chip. It steps through charge acquisition, analogue-to-digital conversion and data readout, and between those bursts it holds the chip in a powered-down idle phase. It drives one power enable for each of three pulsed stages (analog, ADC, digital) and reports the current phase. In normal use the active part of the cycle takes about 2 ms in a 200 ms period, so the stages draw power for roughly 1% of the time.

Two operating modes exist. In collider mode the burst repeats on a fixed, programmable period and the spill input is ignored. In beam-test mode the spill input gates the sequence: bursts run back to back while spill is high, and the block rests in idle while it is low. A spill that ends mid-burst cuts acquisition short, but conversion and readout still complete. An optional warm-up phase powers the analog stage a programmable number of cycles before acquisition begins.

All durations are cycle counts taken from input ports, so a system can set real-time values while a bench uses short ones. The enable pattern of each active phase comes from its own three-bit mask.

Top module: `pulse_phase_seq`

## Requirements
- R1: While rst_ni is low and right after its release, phase_o is 0 (idle) and pwr_en_o is 0. Phase codes: 0 idle, 1 warm-up, 2 acquisition, 3 conversion, 4 readout.
- R2: Acquisition is always followed by conversion, and conversion by readout. Acquisition, conversion and readout last acq_len_i, conv_len_i and read_len_i cycles. A length of 0 acts as 1.
- R3: In collider mode (beam_mode_i=0), acquisition begins period_len_i cycles after reset release and every period_len_i cycles after that. spill_i has no effect in this mode.
- R4: In idle every bit of pwr_en_o is 0.
- R5: pwr_en_o bit 0 is analog, bit 1 is ADC and bit 2 is digital. During acquisition, conversion and readout, pwr_en_o equals acq_en_i, conv_en_i and read_en_i respectively. It changes in the same cycle as phase_o.
- R6: With settle_len_i>0, a warm-up phase of settle_len_i cycles comes before each acquisition. During warm-up pwr_en_o equals acq_en_i & 3'b001. In collider mode warm-up does not move the acquisition start. With settle_len_i=0 there is no warm-up phase.
- R7: In beam-test mode the block stays in idle while spill_i is low. Spill high in idle starts warm-up (or acquisition) in the next cycle.
- R8: In beam-test mode, if spill_i is high in the last readout cycle, the next burst starts in the next cycle with no idle phase.
- R9: In beam-test mode, spill_i low during acquisition moves to conversion in the next cycle, and readout then completes before idle. Spill low during warm-up returns to idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beam_mode_i | input | 1 | 1 selects spill-gated beam-test mode |
| spill_i | input | 1 | Spill present |
| period_len_i | input | CNT_W | Collider cycle period in clock cycles |
| settle_len_i | input | CNT_W | Analog warm-up cycles before acquisition |
| acq_len_i | input | CNT_W | Acquisition cycles |
| conv_len_i | input | CNT_W | Conversion cycles |
| read_len_i | input | CNT_W | Readout cycles |
| acq_en_i | input | 3 | Stage enables during acquisition |
| conv_en_i | input | 3 | Stage enables during conversion |
| read_en_i | input | 3 | Stage enables during readout |
| pwr_en_o | output | 3 | Stage power enables {digital, ADC, analog} |
| phase_o | output | 3 | Current phase code |

## Verification
The bench builds the block with CNT_W=12 and drives phase lengths of a few cycles and a 20-cycle period. This keeps complete collider periods, warm-up lead-in and repeated beam-test bursts short enough to observe at exact cycle numbers. With these short lengths a few dozen cycles cover the zero-length corner, spill loss during acquisition and during warm-up, and back-to-back bursts.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned NUM_STG = 3;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WARM = 3'd1,
    PH_ACQ  = 3'd2,
    PH_CONV = 3'd3,
    PH_READ = 3'd4
  } phase_e;
endpackage

// File: rtl/pps_fsm.sv
module pps_fsm import pps_pkg::*; #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beam_mode_i,
  input  logic             spill_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] pcnt_i,
  input  logic [CNT_W-1:0] period_len_i,
  input  logic [CNT_W-1:0] settle_len_i,
  input  logic [CNT_W-1:0] acq_len_i,
  input  logic [CNT_W-1:0] conv_len_i,
  input  logic [CNT_W-1:0] read_len_i,
  output phase_e           phase_q_o,
  output phase_e           phase_d_o
);
  localparam int unsigned EW = CNT_W + 2;

  phase_e phase_q, phase_d;
  logic [EW-1:0] cnt_x;
  logic warm_done, acq_done, conv_done, read_done, period_due;
  phase_e launch;

  assign cnt_x = EW'(cnt_i) + EW'(1);
  // a zero length behaves as one cycle
  assign warm_done  = cnt_x >= EW'(settle_len_i);
  assign acq_done   = cnt_x >= EW'(acq_len_i);
  assign conv_done  = cnt_x >= EW'(conv_len_i);
  assign read_done  = cnt_x >= EW'(read_len_i);
  assign period_due = EW'(pcnt_i) + EW'(settle_len_i) + EW'(1) >= EW'(period_len_i);
  assign launch     = (settle_len_i == '0) ? PH_ACQ : PH_WARM;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (beam_mode_i) begin
          if (spill_i) phase_d = launch;
        end else if (period_due) begin
          phase_d = launch;
        end
      end
      PH_WARM: begin
        if (beam_mode_i && !spill_i) phase_d = PH_IDLE;
        else if (warm_done)          phase_d = PH_ACQ;
      end
      PH_ACQ: begin
        if ((beam_mode_i && !spill_i) || acq_done) phase_d = PH_CONV;
      end
      PH_CONV: begin
        if (conv_done) phase_d = PH_READ;
      end
      PH_READ: begin
        if (read_done) phase_d = (beam_mode_i && spill_i) ? launch : PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;

  // R2
  acq_to_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACQ) |=> (phase_q == PH_ACQ || phase_q == PH_CONV));
  // R2
  conv_to_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CONV) |=> (phase_q == PH_CONV || phase_q == PH_READ));
  // R7
  beam_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beam_mode_i && !spill_i && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE));
  // R9
  spill_loss_acq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beam_mode_i && !spill_i && phase_q == PH_ACQ) |=> (phase_q == PH_CONV));
endmodule

// File: rtl/pps_timer.sv
module pps_timer import pps_pkg::*; #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_q_i,
  input  phase_e           phase_d_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pcnt_o
);
  logic [CNT_W-1:0] cnt_q, pcnt_q;

  // cnt: cycles in current phase; pcnt: cycles since last acquisition start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (phase_d_i != phase_q_i) cnt_q <= '0;
      else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
      if (phase_d_i == PH_ACQ && phase_q_i != PH_ACQ) pcnt_q <= '0;
      else if (pcnt_q != '1)                          pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign pcnt_o = pcnt_q;

  // R2
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_d_i != phase_q_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pps_stage_en.sv
module pps_stage_en import pps_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  phase_e             phase_d_i,
  input  logic [NUM_STG-1:0] acq_en_i,
  input  logic [NUM_STG-1:0] conv_en_i,
  input  logic [NUM_STG-1:0] read_en_i,
  output logic [NUM_STG-1:0] en_o
);
  localparam logic [NUM_STG-1:0] ANALOG_ONLY = NUM_STG'(1);

  logic [NUM_STG-1:0] sel;

  always_comb begin
    unique case (phase_d_i)
      PH_WARM: sel = acq_en_i & ANALOG_ONLY;
      PH_ACQ:  sel = acq_en_i;
      PH_CONV: sel = conv_en_i;
      PH_READ: sel = read_en_i;
      default: sel = '0;
    endcase
  end

  // registered per stage so enables switch with the phase register
  for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= sel[s];
    end
    assign en_o[s] = en_q;
  end
endmodule

// File: rtl/pulse_phase_seq.sv
module pulse_phase_seq import pps_pkg::*; #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beam_mode_i,
  input  logic             spill_i,
  input  logic [CNT_W-1:0] period_len_i,
  input  logic [CNT_W-1:0] settle_len_i,
  input  logic [CNT_W-1:0] acq_len_i,
  input  logic [CNT_W-1:0] conv_len_i,
  input  logic [CNT_W-1:0] read_len_i,
  input  logic [2:0]       acq_en_i,
  input  logic [2:0]       conv_en_i,
  input  logic [2:0]       read_en_i,
  output logic [2:0]       pwr_en_o,
  output logic [2:0]       phase_o
);
  phase_e phase_q, phase_d;
  logic [CNT_W-1:0] cnt, pcnt;

  pps_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .beam_mode_i, .spill_i,
    .cnt_i(cnt), .pcnt_i(pcnt),
    .period_len_i, .settle_len_i, .acq_len_i, .conv_len_i, .read_len_i,
    .phase_q_o(phase_q), .phase_d_o(phase_d)
  );

  pps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .phase_q_i(phase_q), .phase_d_i(phase_d),
    .cnt_o(cnt), .pcnt_o(pcnt)
  );

  pps_stage_en u_en (
    .clk_i, .rst_ni, .phase_d_i(phase_d),
    .acq_en_i, .conv_en_i, .read_en_i, .en_o(pwr_en_o)
  );

  assign phase_o = phase_q;

  // R4
  idle_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0) |-> (pwr_en_o == 3'b000));
  // R6
  warm_analog_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |-> (pwr_en_o[2:1] == 2'b00));
endmodule

// File: tb/sim_pulse_phase_seq.sv
module sim_pulse_phase_seq;
  localparam int CLK_NS = 10;
  localparam int CW = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic beam_mode = 1'b0, spill = 1'b0;
  logic [CW-1:0] period_len, settle_len, acq_len, conv_len, read_len;
  logic [2:0] acq_en, conv_en, read_en, pwr_en, phase;
  int n_chk = 0, n_fail = 0, ecnt = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pulse_phase_seq #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni, .beam_mode_i(beam_mode), .spill_i(spill),
    .period_len_i(period_len), .settle_len_i(settle_len),
    .acq_len_i(acq_len), .conv_len_i(conv_len), .read_len_i(read_len),
    .acq_en_i(acq_en), .conv_en_i(conv_en), .read_en_i(read_en),
    .pwr_en_o(pwr_en), .phase_o(phase)
  );

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: got %0d expected %0d", req, ecnt, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    ecnt = 0;
    #1;
  endtask

  task automatic go(int k);
    while (ecnt < k) begin @(posedge clk); ecnt++; end
    #2;
  endtask

  task automatic setup(logic bm, int per, int st, int a, int c, int r);
    beam_mode = bm; period_len = CW'(per); settle_len = CW'(st);
    acq_len = CW'(a); conv_len = CW'(c); read_len = CW'(r);
    acq_en = 3'b101; conv_en = 3'b010; read_en = 3'b100;
  endtask

  task automatic t_collider();
    setup(1'b0, 20, 0, 4, 2, 2);
    spill = 1'b1;
    do_reset();
    chk("R1 phase", phase, 3'd0); chk("R1 pwr", pwr_en, 3'b000);
    go(10); chk("R3 spill ignored", phase, 3'd0); chk("R4 idle pwr", pwr_en, 3'b000);
    go(19); chk("R3 before start", phase, 3'd0);
    go(20); chk("R3 acq start", phase, 3'd2); chk("R5 acq mask", pwr_en, 3'b101);
    go(23); chk("R2 acq length", phase, 3'd2);
    go(24); chk("R2 conv", phase, 3'd3); chk("R5 conv mask", pwr_en, 3'b010);
    go(26); chk("R2 read", phase, 3'd4); chk("R5 read mask", pwr_en, 3'b100);
    go(28); chk("R2 back to idle", phase, 3'd0); chk("R4 idle pwr", pwr_en, 3'b000);
    go(39); chk("R3 period", phase, 3'd0);
    go(40); chk("R3 second acq", phase, 3'd2);
  endtask

  task automatic t_settle();
    setup(1'b0, 20, 3, 4, 2, 2);
    spill = 1'b0;
    do_reset();
    go(16); chk("R6 idle before warm", phase, 3'd0);
    go(17); chk("R6 warm", phase, 3'd1); chk("R6 warm pwr", pwr_en, 3'b001);
    go(19); chk("R6 warm length", phase, 3'd1);
    go(20); chk("R6 acq on time", phase, 3'd2); chk("R5 acq mask", pwr_en, 3'b101);
  endtask

  task automatic t_beam();
    setup(1'b1, 20, 0, 4, 2, 2);
    spill = 1'b0;
    do_reset();
    go(10); chk("R7 idle no spill", phase, 3'd0);
    spill = 1'b1;
    go(11); chk("R7 spill start", phase, 3'd2);
    go(15); chk("R2 beam conv", phase, 3'd3);
    go(17); chk("R2 beam read", phase, 3'd4);
    go(19); chk("R8 back to back", phase, 3'd2);
    go(20); spill = 1'b0;
    go(21); chk("R9 acq cut", phase, 3'd3);
    go(23); chk("R9 read completes", phase, 3'd4);
    go(25); chk("R9 idle after read", phase, 3'd0);
    go(30); chk("R7 stays idle", phase, 3'd0);
  endtask

  task automatic t_warm_abort();
    setup(1'b1, 20, 3, 4, 2, 2);
    spill = 1'b0;
    acq_en = 3'b110;
    do_reset();
    go(5); spill = 1'b1;
    go(6); chk("R6 beam warm", phase, 3'd1); chk("R6 warm masked", pwr_en, 3'b000);
    go(7); spill = 1'b0;
    go(8); chk("R9 warm abort", phase, 3'd0);
  endtask

  task automatic t_zero_len();
    setup(1'b1, 20, 0, 1, 0, 0);
    spill = 1'b0;
    do_reset();
    go(2); spill = 1'b1;
    go(3); chk("R2 acq", phase, 3'd2);
    go(4); chk("R2 zero conv", phase, 3'd3);
    go(5); chk("R2 zero read", phase, 3'd4);
    go(6); chk("R8 restart", phase, 3'd2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_collider();
    t_settle();
    t_beam();
    t_warm_abort();
    t_zero_len();
    finish_run();
  end

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule